// File: doc/BRIEF.md
# Coefficient Quantizer with Block Statistics

This block turns a stream of signed 16-bit transform coefficients into signed quantized levels, one coefficient per cycle. Coefficients arrive in groups of sixteen, and each group is one 4x4 block. Each coefficient's magnitude has a rounding offset added and is then scaled by a multiplier. The offset and multiplier come from eight-entry tables, selected by the coefficient's position within the block. The result is truncated by sixteen bits, and the sign is restored afterwards.

For each block the quantizer also reports two statistics: how many of its levels are nonzero, and the largest unsigned magnitude it produced. Both are given with a one-cycle completion strobe. A DC mode replaces both table lookups with one scalar offset and one scalar multiplier for every position. The tables are written through a separate port while no block is partly received.

Top module: `coef_quant`

## Requirements
- R1: The magnitude is `((|coef| + off) * mul) >> 16`. `|coef|` and the sum wrap to 16 bits. The sum and the multiplier are multiplied as signed 16-bit values to a 32-bit product, and bits 31:16 are kept.
- R2: A coefficient greater than zero outputs the magnitude unchanged. A zero or negative coefficient outputs the two's complement negation of the magnitude, so a zero input with a nonzero magnitude gives a negative level.
- R3: The coefficient at position p (0..15) within a block uses table entry `p mod 8`, addressed by `tbl_addr`.
- R4: While `dc_mode` is 1, every position uses `dc_off` and `dc_mul` instead of the tables. The expected offset range is 0 to 768.
- R5: `blk_nz` equals 16 minus the number of zero levels in the finished block.
- R6: `blk_max` is the largest of the block's sixteen unsigned magnitudes, taken before the sign is restored.
- R7: `blk_done` pulses for one cycle, one cycle after the sixteenth level of a block appears. Back-to-back blocks each produce their own pulse and statistics, in block order.
- R8: A coefficient accepted by the valid/ready handshake appears on `lvl_data`, with `lvl_valid` high, in the following cycle. `lvl_valid` is low in the cycle after a cycle with no accept.
- R9: A table write is performed only when no block is partly received. While a write is performed, `in_ready` is low. A write issued in the middle of a block is ignored and leaves `in_ready` high.
- R10: After reset, `lvl_valid` and `blk_done` are low, `in_ready` is high and the next coefficient is position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Coefficient valid |
| in_ready | output | 1 | Coefficient can be accepted |
| in_coef | input | 16 | Signed coefficient |
| dc_mode | input | 1 | Use the scalar offset and multiplier |
| dc_off | input | 16 | Scalar rounding offset |
| dc_mul | input | 16 | Scalar multiplier |
| tbl_we | input | 1 | Table write request |
| tbl_addr | input | 3 | Table entry to write |
| tbl_off | input | 16 | Offset value to write |
| tbl_mul | input | 16 | Multiplier value to write |
| lvl_valid | output | 1 | Level valid |
| lvl_data | output | 16 | Signed quantized level |
| blk_done | output | 1 | Block statistics valid strobe |
| blk_nz | output | 5 | Nonzero level count of the last block |
| blk_max | output | 16 | Largest magnitude of the last block |

## Verification
Two back-to-back table-driven blocks mix several kinds of coefficient:
- Zero coefficients at positions with a zero and a nonzero offset separate the negate-on-non-positive rule from a plain sign copy.
- Extreme values (32767, -32768) expose any difference in the wrap of the absolute value and the sum, and in the signed product.
- Small values give zero levels, which move the nonzero count.

A DC-mode block with a large offset shows whether the scalars replace the tables at every position. A table write made while idle shows that the new entry is used. A table write made mid-block shows that the entry is left unchanged, through the level of a later coefficient that reads that entry.

// File: rtl/qnt_pkg.sv
package qnt_pkg;
  localparam int CW = 16;
  localparam int PW = 2 * CW;

  // absolute value with 16-bit wrap (most negative stays 0x8000)
  function automatic logic [CW-1:0] abs_wrap(input logic [CW-1:0] c);
    return c[CW-1] ? (~c + 1'b1) : c;
  endfunction

  // offset, signed multiply, keep upper half
  function automatic logic [CW-1:0] q_mag(input logic [CW-1:0] c,
                                          input logic [CW-1:0] off,
                                          input logic [CW-1:0] mul);
    logic [CW-1:0] s;
    logic signed [PW-1:0] p;
    s = abs_wrap(c) + off;
    p = $signed(s) * $signed(mul);
    return p[PW-1:CW];
  endfunction

  // positive input keeps the magnitude, others negate it
  function automatic logic [CW-1:0] q_sign(input logic [CW-1:0] c,
                                           input logic [CW-1:0] mag);
    return ($signed(c) > 0) ? mag : (~mag + 1'b1);
  endfunction
endpackage

// File: rtl/qnt_table.sv
module qnt_table #(
  parameter int N  = 8,
  parameter int AW = $clog2(N)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [qnt_pkg::CW-1:0] woff,
  input  logic [qnt_pkg::CW-1:0] wmul,
  input  logic [AW-1:0]          raddr,
  output logic [qnt_pkg::CW-1:0] roff,
  output logic [qnt_pkg::CW-1:0] rmul
);
  logic [qnt_pkg::CW-1:0] off_q [N];
  logic [qnt_pkg::CW-1:0] mul_q [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        off_q[i] <= '0;
        mul_q[i] <= '0;
      end else if (we && waddr == AW'(i)) begin
        off_q[i] <= woff;
        mul_q[i] <= wmul;
      end
    end
  end

  assign roff = off_q[raddr];
  assign rmul = mul_q[raddr];
endmodule

// File: rtl/qnt_lane.sv
module qnt_lane (
  input  logic [qnt_pkg::CW-1:0] coef,
  input  logic [qnt_pkg::CW-1:0] off,
  input  logic [qnt_pkg::CW-1:0] mul,
  output logic [qnt_pkg::CW-1:0] mag,
  output logic [qnt_pkg::CW-1:0] level,
  output logic                   is_zero
);
  always_comb begin
    mag     = qnt_pkg::q_mag(coef, off, mul);
    level   = qnt_pkg::q_sign(coef, mag);
    is_zero = (level == '0);
  end
endmodule

// File: rtl/qnt_stats.sv
module qnt_stats #(
  parameter int BLK_N = 16,
  parameter int NZW   = $clog2(BLK_N + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc,
  input  logic                   last_acc,
  input  logic                   zero_lvl,
  input  logic [qnt_pkg::CW-1:0] mag,
  output logic                   done,
  output logic [NZW-1:0]         nz,
  output logic [qnt_pkg::CW-1:0] max
);
  logic [NZW-1:0]         zc_q;
  logic [qnt_pkg::CW-1:0] mx_q;
  logic                   fresh_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zc_q    <= '0;
      mx_q    <= '0;
      fresh_q <= 1'b1;
      last_q  <= 1'b0;
      done    <= 1'b0;
      nz      <= '0;
      max     <= '0;
    end else begin
      last_q <= last_acc;
      done   <= last_q;
      if (last_q) begin
        nz  <= NZW'(BLK_N) - zc_q;
        max <= mx_q;
      end
      if (acc) begin
        fresh_q <= last_acc;
        if (fresh_q) begin
          zc_q <= NZW'(zero_lvl);
          mx_q <= mag;
        end else begin
          zc_q <= zc_q + NZW'(zero_lvl);
          mx_q <= (mag > mx_q) ? mag : mx_q;
        end
      end
    end
  end
endmodule

// File: rtl/coef_quant.sv
module coef_quant #(
  parameter int TBL_N = 8,
  parameter int BLK_N = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_coef,
  input  logic        dc_mode,
  input  logic [15:0] dc_off,
  input  logic [15:0] dc_mul,
  input  logic        tbl_we,
  input  logic [2:0]  tbl_addr,
  input  logic [15:0] tbl_off,
  input  logic [15:0] tbl_mul,
  output logic        lvl_valid,
  output logic [15:0] lvl_data,
  output logic        blk_done,
  output logic [4:0]  blk_nz,
  output logic [15:0] blk_max
);
  localparam int PIW = $clog2(BLK_N);
  localparam int TIW = $clog2(TBL_N);
  localparam int NZW = $clog2(BLK_N + 1);

  logic [PIW-1:0] pos_q;
  logic           blk_idle, tbl_wr_ok, acc, last_acc;
  logic [15:0]    t_off, t_mul, sel_off, sel_mul;
  logic [15:0]    lane_mag, lane_lvl;
  logic           lane_zero;

  assign blk_idle  = (pos_q == '0);
  assign tbl_wr_ok = tbl_we && blk_idle;
  assign in_ready  = !tbl_wr_ok;
  assign acc       = in_valid && in_ready;
  assign last_acc  = acc && (pos_q == PIW'(BLK_N - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        pos_q <= '0;
    else if (last_acc) pos_q <= '0;
    else if (acc)      pos_q <= pos_q + 1'b1;
  end

  qnt_table #(.N(TBL_N), .AW(TIW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_wr_ok), .waddr(tbl_addr[TIW-1:0]),
    .woff(tbl_off), .wmul(tbl_mul), .raddr(pos_q[TIW-1:0]),
    .roff(t_off), .rmul(t_mul)
  );

  assign sel_off = dc_mode ? dc_off : t_off;
  assign sel_mul = dc_mode ? dc_mul : t_mul;

  qnt_lane u_lane (
    .coef(in_coef), .off(sel_off), .mul(sel_mul),
    .mag(lane_mag), .level(lane_lvl), .is_zero(lane_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_valid <= 1'b0;
      lvl_data  <= '0;
    end else begin
      lvl_valid <= acc;
      if (acc) lvl_data <= lane_lvl;
    end
  end

  qnt_stats #(.BLK_N(BLK_N), .NZW(NZW)) u_stats (
    .clk(clk), .rst_n(rst_n), .acc(acc), .last_acc(last_acc),
    .zero_lvl(lane_zero), .mag(lane_mag),
    .done(blk_done), .nz(blk_nz), .max(blk_max)
  );
endmodule

// File: rtl/qnt_chk.sv
module qnt_chk #(
  parameter int PIW   = 4,
  parameter int NZW   = 5,
  parameter int BLK_N = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [15:0]    in_coef,
  input logic           tbl_we,
  input logic [PIW-1:0] pos_q,
  input logic           last_acc,
  input logic [15:0]    lane_mag,
  input logic           lvl_valid,
  input logic [15:0]    lvl_data,
  input logic           blk_done,
  input logic [NZW-1:0] blk_nz
);
  p_lvl_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> lvl_valid);
  p_lvl_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !lvl_valid);
  p_pos_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && $signed(in_coef) > 0) |=> lvl_data == $past(lane_mag));
  p_nonpos_neg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && $signed(in_coef) <= 0) |=> 16'(lvl_data + $past(lane_mag)) == 16'd0);
  p_done_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_acc |=> ##1 blk_done);
  p_nz_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> blk_nz <= NZW'(BLK_N));
  p_midblock_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != '0 && tbl_we) |-> in_ready);
endmodule

bind coef_quant qnt_chk #(.PIW(PIW), .NZW(NZW), .BLK_N(BLK_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_coef(in_coef), .tbl_we(tbl_we), .pos_q(pos_q), .last_acc(last_acc),
  .lane_mag(lane_mag), .lvl_valid(lvl_valid), .lvl_data(lvl_data),
  .blk_done(blk_done), .blk_nz(blk_nz)
);

// File: tb/tb_coef_quant.sv
module tb_coef_quant;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, dc_mode, tbl_we;
  logic [15:0] in_coef, dc_off, dc_mul, tbl_off, tbl_mul;
  logic [2:0]  tbl_addr;
  logic        lvl_valid, blk_done;
  logic [15:0] lvl_data, blk_max;
  logic [4:0]  blk_nz;

  always #10 clk = ~clk;

  coef_quant dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .dc_mode(dc_mode), .dc_off(dc_off), .dc_mul(dc_mul),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_off(tbl_off), .tbl_mul(tbl_mul),
    .lvl_valid(lvl_valid), .lvl_data(lvl_data), .blk_done(blk_done),
    .blk_nz(blk_nz), .blk_max(blk_max)
  );

  localparam logic [15:0] VEC [32] = '{
    16'd0, 16'd0, -16'sd100, 16'd5000, -16'sd5000, 16'd1, -16'sd1, 16'd32767,
    16'h8000, 16'd200, 16'd0, -16'sd3, 16'd700, 16'd12000, -16'sd250, 16'd60,
    16'd0, 16'd1, -16'sd1, 16'd2, -16'sd2, 16'd0, 16'd3, -16'sd3,
    16'd4, 16'd0, 16'd9000, -16'sd9000, 16'd30000, -16'sd30000, 16'd0, 16'd15
  };

  int n_chk = 0, n_bad = 0;
  int s_zc = 0, s_mx = 0;
  logic [15:0] m_off [8];
  logic [15:0] m_mul [8];
  logic [15:0] buf_c [32];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mdl_mag(input logic [15:0] c, input logic [15:0] off, input logic [15:0] mul);
    int a, s, m, p;
    logic [31:0] pv;
    a = c[15] ? (65536 - int'(c)) % 65536 : int'(c);
    s = (a + int'(off)) % 65536;
    if (s >= 32768) s = s - 65536;
    m = (int'(mul) >= 32768) ? int'(mul) - 65536 : int'(mul);
    p = s * m;
    pv = p;
    return pv[31:16];
  endfunction

  function automatic logic [15:0] mdl_lvl(input logic [15:0] c, input logic [15:0] mag);
    if (!c[15] && c != 16'd0) return mag;
    return 16'(17'h10000 - {1'b0, mag});
  endfunction

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic load_tbl(input int i, input logic [15:0] o, input logic [15:0] m);
    in_valid = 1'b0; tbl_we = 1'b1; tbl_addr = 3'(i); tbl_off = o; tbl_mul = m;
    @(negedge clk);
    tbl_we = 1'b0;
    m_off[i] = o; m_mul[i] = m;
  endtask

  // sends n coefficients from buf_c starting at block position sp
  task automatic send_run(input int n, input int sp, input bit dc, input string req);
    for (int k = 0; k < n; k++) begin
      int p;
      logic [15:0] mg, lv, o, m;
      p = (sp + k) % 16;
      in_valid = 1'b1; in_coef = buf_c[k]; dc_mode = dc;
      o = dc ? dc_off : m_off[p % 8];
      m = dc ? dc_mul : m_mul[p % 8];
      mg = mdl_mag(buf_c[k], o, m);
      lv = mdl_lvl(buf_c[k], mg);
      @(negedge clk);
      chk(req, "level", {16'd0, lvl_data}, {16'd0, lv});
      chk("R8", "lvl_valid", {31'd0, lvl_valid}, 32'd1);
      if (p == 0 && k > 0) begin
        chk("R7", "blk_done", {31'd0, blk_done}, 32'd1);
        chk("R5", "blk_nz", {27'd0, blk_nz}, 32'(16 - s_zc));
        chk("R6", "blk_max", {16'd0, blk_max}, 32'(s_mx));
        s_zc = 0; s_mx = 0;
      end else begin
        chk("R7", "no blk_done", {31'd0, blk_done}, 32'd0);
      end
      if (lv == 16'd0) s_zc++;
      if (int'(mg) > s_mx) s_mx = int'(mg);
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8", "lvl_valid idle", {31'd0, lvl_valid}, 32'd0);
    if ((sp + n) % 16 == 0) begin
      chk("R7", "blk_done tail", {31'd0, blk_done}, 32'd1);
      chk("R5", "blk_nz tail", {27'd0, blk_nz}, 32'(16 - s_zc));
      chk("R6", "blk_max tail", {16'd0, blk_max}, 32'(s_mx));
      s_zc = 0; s_mx = 0;
    end else begin
      chk("R7", "no done tail", {31'd0, blk_done}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_coef = '0; dc_mode = 1'b0;
    dc_off = '0; dc_mul = '0; tbl_we = 1'b0; tbl_addr = '0; tbl_off = '0; tbl_mul = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "lvl_valid", {31'd0, lvl_valid}, 32'd0);
    chk("R10", "blk_done", {31'd0, blk_done}, 32'd0);
    chk("R10", "in_ready", {31'd0, in_ready}, 32'd1);

    load_tbl(0, 16'd0,   16'd13107);
    load_tbl(1, 16'd21,  16'd11916);
    load_tbl(2, 16'd170, 16'd10082);
    load_tbl(3, 16'd341, 16'd9362);
    load_tbl(4, 16'd682, 16'd8192);
    load_tbl(5, 16'd10,  16'd7282);
    load_tbl(6, 16'd5,   16'd6554);
    load_tbl(7, 16'd768, 16'd5825);

    // R1 R2 R3: two back-to-back blocks from the vector table
    for (int k = 0; k < 32; k++) buf_c[k] = VEC[k];
    send_run(32, 0, 1'b0, "R1 R2 R3");

    // R4: DC mode with a broadcast offset and multiplier
    dc_off = 16'd768; dc_mul = 16'd9000;
    for (int k = 0; k < 16; k++) buf_c[k] = 16'(k * 977 - 6000);
    send_run(16, 0, 1'b1, "R4");

    // R9: idle write stalls the input and takes effect
    in_valid = 1'b1; in_coef = 16'd500; tbl_we = 1'b1; tbl_addr = 3'd0;
    tbl_off = 16'd100; tbl_mul = 16'd20000;
    #1 chk("R9", "in_ready idle write", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    tbl_we = 1'b0; in_valid = 1'b0;
    m_off[0] = 16'd100; m_mul[0] = 16'd20000;
    chk("R9", "no accept during write", {31'd0, lvl_valid}, 32'd0);
    for (int k = 0; k < 3; k++) buf_c[k] = 16'(1000 + k * 300);
    send_run(3, 0, 1'b0, "R3 R9 new entry");

    // R9: mid-block write is ignored
    tbl_we = 1'b1; tbl_addr = 3'd0; tbl_off = 16'd0; tbl_mul = 16'd1;
    #1 chk("R9", "in_ready mid-block", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    tbl_we = 1'b0;
    for (int k = 0; k < 13; k++) buf_c[k] = 16'(-2000 + k * 400);
    send_run(13, 3, 1'b0, "R9 entry unchanged");

    report();
    $finish;
  end
endmodule